// File: doc/BRIEF.md
# Select-Gated Result Queue Port

This block sits behind a packet filter engine and holds the result words the engine produces, one word per processed packet. The words leave the block on a 16-bit result bus. A consumer steps through them with an advance strobe. The strobe counts only while the device's select input is high, because the two inputs are combined as a logical AND. A data-valid output stays high while at least one result is waiting, so the consumer knows when the bus holds a real word.

The same words can be drained through a processor-side register path instead. Each read pops the head word, but only in a cycle in which the port path is not advancing. This keeps the two retrieval paths from ever taking the same entry. If the advance strobe and select are tied low, results stay queued until the processor takes them.

Two devices can share one result bus and one advance line. Only the selected device enables its bus outputs. The output enable is a plain signal, so the board or the surrounding logic can use it to tri-state the bus. A single device may keep select high permanently.

Control is a three-state machine. Its states are `Q_EMPTY` (nothing queued), `Q_PEND` (between one and DEPTH-1 words queued) and `Q_FULL` (DEPTH words queued). Its transitions are:
- `Q_EMPTY`→`Q_PEND` on a stored push.
- `Q_PEND`→`Q_FULL` on a push without a pop when DEPTH-1 words are queued.
- `Q_PEND`→`Q_EMPTY` on a pop without a push when one word is queued.
- `Q_FULL`→`Q_PEND` on any pop.

Every other case holds the current state. DEPTH must be at least 2.

Top module: `rsltq_port`

## Requirements
- R1: `rst_n` is synchronous and active low. Any clock edge with `rst_n` low empties the queue and clears the overflow flag. After such an edge `bus_dv_o`, `cpu_avail_o` and `ovf_o` are 0.
- R2: Words leave the queue in the order in which `res_valid_i` presented them. While select is high and the queue is not empty, `bus_data_o` shows the oldest word.
- R3: A pop happens on each rising edge at which `nxt_i` and `sel_i` are both high and the queue is not empty. From the next cycle the bus shows the following word.
- R4: While `sel_i` is low, `nxt_i` pops nothing and `bus_data_o` is all zeros.
- R5: `bus_dv_o` and `cpu_avail_o` are 1 exactly when at least one word is queued. They fall to 0 in the cycle after the last word is popped.
- R6: A clock edge with `cpu_rd_i` high pops one word only if `nxt_i` AND `sel_i` is low at that edge. When both paths request at the same edge, exactly one word is removed.
- R7: `cpu_rdata_o` shows the oldest queued word with the same bit layout as the bus, and shows zero when the queue is empty.
- R8: The queue holds 16 words. A push that arrives while 16 words are queued is dropped, even if a pop occurs at the same edge. That push sets `ovf_o`, which stays 1 until reset.
- R9: `bus_oe_o` equals `sel_i`. With exclusive selects, two devices sharing the bus never have their output enables high in the same cycle.
- R10: A push and a pop at the same edge leave the number of queued words unchanged. The new word goes behind the remaining ones.
- R11: An advance strobe while the queue is empty changes nothing. The next pushed word is the one presented first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid_i | input | 1 | Filter engine offers a result word this cycle |
| res_data_i | input | 16 | Result word from the filter engine |
| nxt_i | input | 1 | Advance strobe, shared between cascaded devices |
| sel_i | input | 1 | Device select; gates the advance strobe and the bus outputs |
| cpu_rd_i | input | 1 | Processor read of the result register (pops the head) |
| bus_data_o | output | 16 | Result bus data, zero while deselected or empty |
| bus_oe_o | output | 1 | Bus output enable for the shared bus |
| bus_dv_o | output | 1 | At least one result is pending |
| cpu_rdata_o | output | 16 | Result register contents seen by the processor |
| cpu_avail_o | output | 1 | Result register holds a pending word |
| ovf_o | output | 1 | Sticky flag: a result was dropped on a full queue |

## Verification
The assertions assume that every input is a known value once reset is released. They also assume that `rst_n` is held low from time zero until the bench releases it. Because the count assertions isolate pops, they only make a claim in cycles where `res_valid_i` is low. The bench drives every input half a period away from the active edge. In the shared-bus scenario it never raises both selects together, since the exclusive-enable property depends on that.

// File: rtl/rsltq_pkg.sv
package rsltq_pkg;

    // occupancy-driven control states
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PEND  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;

    // which path removes the head word in a cycle
    typedef enum logic [1:0] {
        POP_NONE = 2'd0,
        POP_PORT = 2'd1,
        POP_CPU  = 2'd2
    } pop_src_e;

endpackage

// File: rtl/rsltq_store.sv
module rsltq_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] head_o,
    output logic [CW-1:0]     count_o
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (wr_en) begin
            slots[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + CNT_ONE;
                2'b01:   count <= count - CNT_ONE;
                default: count <= count;
            endcase
        end
    end

    assign head_o  = slots[rd_ptr];
    assign count_o = count;

endmodule

// File: rtl/rsltq_ctrl.sv
module rsltq_ctrl
    import rsltq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic          res_valid_i,
    input  logic          nxt_i,
    input  logic          sel_i,
    input  logic          cpu_rd_i,
    output logic          wr_en_o,
    output logic          rd_en_o,
    output q_state_e      state_o,
    output logic          ovf_o
);

    localparam logic [CW-1:0] ONE_LEFT   = CW'(1);
    localparam logic [CW-1:0] ONE_SHORT  = CW'(DEPTH - 1);

    q_state_e state_q;
    q_state_e state_d;
    pop_src_e pop_src;
    logic     port_req;
    logic     ovf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // sticky drop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (res_valid_i && (state_q == Q_FULL)) begin
            ovf_q <= 1'b1;
        end
    end

    // pop arbitration and push acceptance
    always_comb begin
        port_req = nxt_i & sel_i;
        pop_src  = POP_NONE;
        wr_en_o  = 1'b0;
        unique case (state_q)
            Q_EMPTY: begin
                pop_src = POP_NONE;
                wr_en_o = res_valid_i;
            end
            Q_PEND: begin
                pop_src = port_req ? POP_PORT : (cpu_rd_i ? POP_CPU : POP_NONE);
                wr_en_o = res_valid_i;
            end
            Q_FULL: begin
                pop_src = port_req ? POP_PORT : (cpu_rd_i ? POP_CPU : POP_NONE);
                wr_en_o = 1'b0;
            end
            default: begin
                pop_src = POP_NONE;
                wr_en_o = 1'b0;
            end
        endcase
        rd_en_o = (pop_src != POP_NONE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (wr_en_o) begin
                    state_d = Q_PEND;
                end
            end
            Q_PEND: begin
                if (wr_en_o && !rd_en_o && (count_i == ONE_SHORT)) begin
                    state_d = Q_FULL;
                end else if (rd_en_o && !wr_en_o && (count_i == ONE_LEFT)) begin
                    state_d = Q_EMPTY;
                end
            end
            Q_FULL: begin
                if (rd_en_o) begin
                    state_d = Q_PEND;
                end
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    assign state_o = state_q;
    assign ovf_o   = ovf_q;

endmodule

// File: rtl/rsltq_busdrv.sv
module rsltq_busdrv
    import rsltq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              sel_i,
    input  q_state_e          state_i,
    input  logic [DATA_W-1:0] head_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_oe_o,
    output logic              bus_dv_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              cpu_avail_o
);

    logic pending;

    always_comb begin
        unique case (state_i)
            Q_PEND, Q_FULL: pending = 1'b1;
            default:        pending = 1'b0;
        endcase
        bus_oe_o    = sel_i;
        bus_dv_o    = pending;
        cpu_avail_o = pending;
        bus_data_o  = (sel_i && pending) ? head_i : '0;
        cpu_rdata_o = pending ? head_i : '0;
    end

endmodule

// File: rtl/rsltq_port.sv
module rsltq_port
    import rsltq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid_i,
    input  logic [DATA_W-1:0] res_data_i,
    input  logic              nxt_i,
    input  logic              sel_i,
    input  logic              cpu_rd_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_oe_o,
    output logic              bus_dv_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              cpu_avail_o,
    output logic              ovf_o
);

    localparam int CW = $clog2(DEPTH + 1);

    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] head;
    logic [CW-1:0]     q_count;
    q_state_e          q_state;

    rsltq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (res_data_i),
        .rd_en   (rd_en),
        .head_o  (head),
        .count_o (q_count)
    );

    rsltq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_i     (q_count),
        .res_valid_i (res_valid_i),
        .nxt_i       (nxt_i),
        .sel_i       (sel_i),
        .cpu_rd_i    (cpu_rd_i),
        .wr_en_o     (wr_en),
        .rd_en_o     (rd_en),
        .state_o     (q_state),
        .ovf_o       (ovf_o)
    );

    rsltq_busdrv #(.DATA_W(DATA_W)) u_busdrv (
        .sel_i       (sel_i),
        .state_i     (q_state),
        .head_i      (head),
        .bus_data_o  (bus_data_o),
        .bus_oe_o    (bus_oe_o),
        .bus_dv_o    (bus_dv_o),
        .cpu_rdata_o (cpu_rdata_o),
        .cpu_avail_o (cpu_avail_o)
    );

endmodule

// File: rtl/rsltq_port_chk.sv
module rsltq_port_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid_i,
    input logic              nxt_i,
    input logic              sel_i,
    input logic              cpu_rd_i,
    input logic [DATA_W-1:0] bus_data_o,
    input logic              bus_oe_o,
    input logic              bus_dv_o,
    input logic              ovf_o,
    input logic [CW-1:0]     q_count
);

    localparam logic [CW-1:0] C_ONE  = CW'(1);
    localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (q_count == '0) && !ovf_o);

    // R3
    port_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_i && sel_i && (q_count != '0) && !res_valid_i)
        |=> (q_count + C_ONE) == $past(q_count));

    // R4
    desel_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && !cpu_rd_i && !res_valid_i) |=> q_count == $past(q_count));

    // R4
    desel_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> (bus_data_o == '0) && !bus_oe_o);

    // R5
    dv_tracks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dv_o == (q_count != '0));

    // R6
    one_pop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && (q_count != '0) && !res_valid_i)
        |=> (q_count + C_ONE) == $past(q_count));

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= C_FULL);

    // R8
    drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && (q_count == C_FULL)) |=> ovf_o);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

endmodule

bind rsltq_port rsltq_port_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_valid_i (res_valid_i),
    .nxt_i       (nxt_i),
    .sel_i       (sel_i),
    .cpu_rd_i    (cpu_rd_i),
    .bus_data_o  (bus_data_o),
    .bus_oe_o    (bus_oe_o),
    .bus_dv_o    (bus_dv_o),
    .ovf_o       (ovf_o),
    .q_count     (q_count)
);

// File: tb/rsltq_port_bench.sv
module rsltq_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nxt = 1'b0;
    logic        rv   [2];
    logic        sel  [2];
    logic        rd   [2];
    logic [15:0] din  [2];
    logic [15:0] bdat [2];
    logic [15:0] cdat [2];
    logic        dv   [2];
    logic        oe   [2];
    logic        av   [2];
    logic        ov   [2];

    logic [15:0] mq [2][$];
    logic        movf [2];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rsltq_port u_rsltq_port (
        .clk(clk), .rst_n(rst_n), .res_valid_i(rv[0]), .res_data_i(din[0]),
        .nxt_i(nxt), .sel_i(sel[0]), .cpu_rd_i(rd[0]),
        .bus_data_o(bdat[0]), .bus_oe_o(oe[0]), .bus_dv_o(dv[0]),
        .cpu_rdata_o(cdat[0]), .cpu_avail_o(av[0]), .ovf_o(ov[0])
    );

    rsltq_port u_rsltq_port_b (
        .clk(clk), .rst_n(rst_n), .res_valid_i(rv[1]), .res_data_i(din[1]),
        .nxt_i(nxt), .sel_i(sel[1]), .cpu_rd_i(rd[1]),
        .bus_data_o(bdat[1]), .bus_oe_o(oe[1]), .bus_dv_o(dv[1]),
        .cpu_rdata_o(cdat[1]), .cpu_avail_o(av[1]), .ovf_o(ov[1])
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output against the reference model
    task automatic compare();
        for (int d = 0; d < 2; d++) begin
            int sz = mq[d].size();
            logic [15:0] hd = (sz > 0) ? mq[d][0] : 16'h0;
            chk("R5 data valid", {15'd0, dv[d]}, {15'd0, sz > 0});
            chk("R5 cpu avail", {15'd0, av[d]}, {15'd0, sz > 0});
            chk("R9 output enable", {15'd0, oe[d]}, {15'd0, sel[d]});
            chk(sel[d] ? "R2 bus head" : "R4 bus quiet", bdat[d],
                (sel[d] && sz > 0) ? hd : 16'h0);
            chk("R7 cpu head", cdat[d], hd);
            chk("R8 overflow", {15'd0, ov[d]}, {15'd0, movf[d]});
        end
        chk("R9 exclusive enable", {15'd0, oe[0] & oe[1]}, 16'h0);
    endtask

    task automatic model_edge();
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                mq[d].delete();
                movf[d] = 1'b0;
            end else begin
                int  sz = mq[d].size();
                bit  full = (sz == 16);
                bit  pop = (sz > 0) && ((nxt && sel[d]) || rd[d]);
                if (rv[d] && full) movf[d] = 1'b1;
                if (pop) void'(mq[d].pop_front());
                if (rv[d] && !full) mq[d].push_back(din[d]);
            end
        end
    endtask

    // inputs are set at the falling edge before calling
    task automatic step();
        #1;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic push(input int d, input logic [15:0] v);
        rv[d] = 1'b1;
        din[d] = v;
        step();
        rv[d] = 1'b0;
    endtask

    task automatic advance();
        nxt = 1'b1;
        step();
        nxt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            rv[d] = 1'b0; sel[d] = 1'b0; rd[d] = 1'b0; din[d] = 16'h0; movf[d] = 1'b0;
        end
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 dv after reset", {15'd0, dv[0]}, 16'h0);
        chk("R1 avail after reset", {15'd0, av[0]}, 16'h0);
        chk("R1 ovf after reset", {15'd0, ov[0]}, 16'h0);

        // R2 / R3 ordering and advance
        for (int i = 1; i <= 5; i++) push(0, 16'hA000 + 16'(i));
        sel[0] = 1'b1;
        step();
        chk("R2 first word", bdat[0], 16'hA001);
        advance();
        chk("R3 advanced word", bdat[0], 16'hA002);
        for (int i = 0; i < 4; i++) advance();
        chk("R5 dv after last pop", {15'd0, dv[0]}, 16'h0);

        // R4 advance ignored while deselected
        for (int i = 1; i <= 3; i++) push(0, 16'hB000 + 16'(i));
        sel[0] = 1'b0;
        for (int i = 0; i < 4; i++) advance();
        chk("R4 bus zero deselected", bdat[0], 16'h0);
        sel[0] = 1'b1;
        step();
        chk("R4 head kept", bdat[0], 16'hB001);
        chk("R7 cpu matches bus", cdat[0], bdat[0]);

        // R6 processor path
        sel[0] = 1'b0;
        rd[0] = 1'b1;
        step();
        chk("R6 cpu read popped", cdat[0], 16'hB002);
        sel[0] = 1'b1;
        advance();
        rd[0] = 1'b0;
        chk("R6 single pop on collision", cdat[0], 16'hB003);
        advance();
        chk("R6 drained", {15'd0, av[0]}, 16'h0);

        // R8 full queue drops and flags
        for (int i = 0; i < 18; i++) push(0, 16'hC000 + 16'(i));
        chk("R8 overflow set", {15'd0, ov[0]}, 16'h1);
        for (int i = 0; i < 16; i++) begin
            chk("R8 stored word", bdat[0], 16'hC000 + 16'(i));
            advance();
        end
        chk("R8 sixteen only", {15'd0, dv[0]}, 16'h0);
        chk("R8 flag sticky", {15'd0, ov[0]}, 16'h1);

        // R10 simultaneous push and pop
        push(0, 16'hD001);
        rv[0] = 1'b1; din[0] = 16'hD002; nxt = 1'b1;
        step();
        rv[0] = 1'b0; nxt = 1'b0;
        chk("R10 new head", bdat[0], 16'hD002);
        chk("R10 still pending", {15'd0, dv[0]}, 16'h1);
        advance();
        chk("R10 then empty", {15'd0, dv[0]}, 16'h0);

        // R11 advance on empty
        for (int i = 0; i < 3; i++) advance();
        chk("R11 empty stays empty", {15'd0, dv[0]}, 16'h0);
        push(0, 16'hE001);
        chk("R11 pushed word first", bdat[0], 16'hE001);
        advance();

        // R9 two devices on one bus
        for (int i = 0; i < 4; i++) begin
            push(0, 16'h1100 + 16'(i));
            push(1, 16'h2200 + 16'(i));
        end
        sel[0] = 1'b1; sel[1] = 1'b0;
        advance(); advance();
        sel[0] = 1'b0; step();
        sel[1] = 1'b1;
        step();
        chk("R9 device b drives", bdat[1], 16'h2200);
        chk("R9 device a quiet", bdat[0], 16'h0);
        advance(); advance();
        chk("R9 b advanced alone", bdat[1], 16'h2202);
        chk("R9 a untouched", cdat[0], 16'h1102);

        // R1 reset with pending work
        sel[1] = 1'b0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 a cleared", {15'd0, dv[0]}, 16'h0);
        chk("R1 b cleared", {15'd0, dv[1]}, 16'h0);
        chk("R1 ovf cleared", {15'd0, ov[0]}, 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule